// File: doc/BRIEF.md
# PCI Inbound Memory Address Decoder

This block sits on the target side of a host-mode PCI bridge and classifies every inbound memory cycle address. For each address presented with a strobe it decides whether the bridge claims the cycle. A claimed cycle goes to one of two targets: the local memory or a 4 KB window of runtime registers. The block also produces the address that the chosen target sees. Memory is 0-based. An optional alias window near the top of the 32-bit space is folded into the bottom 16 MB of local memory by clearing the top address byte. An optional legacy hole between 640 KB and 1 MB can be punched out of memory. The 16 MB segment just above the alias window never reaches memory.

Software-visible configuration comes through a small write port. It holds two enables, the register window base and the top-of-memory limit. A write that would put the register window base outside its permitted ranges is refused and flagged. All decode outputs are registered and appear one clock after the strobe.

Top module: `pci_inb_decode`

## Requirements
- R1: Reset clears out_valid, out_claim, out_tgt, out_addr and cfg_err, clears both enables and top-of-memory to 0, and sets the register window base to 0x8000_0000.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. The other outputs load only on a strobe and hold otherwise.
- R3: With the alias enable set (control write, cfg_sel=2'b00, bit 0), an address 0xFDxx_xxxx outside the register window is claimed with out_tgt=2'b01 (memory) and out_addr = {8'h00, addr[23:0]}.
- R4: With the alias enable clear, an address 0xFDxx_xxxx is not claimed.
- R5: An address 0xFExx_xxxx is never sent to memory. It is claimed only when it falls in the register window.
- R6: An address whose bits [31:12] equal the register window base is claimed with out_tgt=2'b10 (registers) and out_addr = {20'h0, addr[11:0]}.
- R7: The register window takes priority over the alias, reserved, hole and memory decodes.
- R8: A base write (cfg_sel=2'b01) is accepted only when cfg_wdata lies in 0x8000_0000–0xFCFF_FFFF or 0xFE00_0000–0xFEFF_FFFF. Bits [11:0] are dropped. Otherwise the old base is kept and cfg_err is high for the single cycle after the write.
- R9: With the hole enable set (control bit 1), addresses 0x000A_0000–0x000F_FFFF are not claimed. With it clear, they decode as ordinary memory.
- R10: An address below top-of-memory (cfg_sel=2'b10) that hits no other range is claimed as memory with the address unchanged. Otherwise it is unclaimed, with out_tgt=2'b00 and out_addr=0.
- R11: A configuration write in the same cycle as a strobe does not affect that strobe. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 32 | Inbound PCI memory address |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | 00 control, 01 register base, 10 top-of-memory, 11 no effect |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | One-cycle pulse after a refused base write |
| out_valid | output | 1 | Decode result valid |
| out_claim | output | 1 | Cycle is claimed by the bridge |
| out_tgt | output | 2 | 00 none, 01 memory, 10 registers |
| out_addr | output | 32 | Translated target address |

## Verification
Two things can fall in the same cycle: a configuration write and an address strobe. The bench provokes this by raising both in one cycle, enabling the alias while strobing an alias address. It judges the result by the strobe being refused first and claimed on a repeat strobe. Decode ranges can also overlap in one address. The bench places the register window inside the reserved segment and again inside memory below top-of-memory, and expects the register target each time.

// File: rtl/pcidec_pkg.sv
`timescale 1ns/1ps
package pcidec_pkg;
  localparam int ADDR_W   = 32;
  localparam int WIN_LG2  = 12;
  localparam int SEG_W    = 8;
  localparam int SEG_LSB  = ADDR_W - SEG_W;
  localparam int BASE_W   = ADDR_W - WIN_LG2;
  localparam int N_LEGAL  = 2;

  localparam logic [SEG_W-1:0]  SEG_ALIAS = 8'hFD;
  localparam logic [SEG_W-1:0]  SEG_RSVD  = 8'hFE;
  localparam logic [ADDR_W-1:0] HOLE_LO   = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] HOLE_HI   = 32'h000F_FFFF;
  localparam logic [ADDR_W-1:0] BASE_RST  = 32'h8000_0000;

  localparam logic [N_LEGAL-1:0][ADDR_W-1:0] LEGAL_LO = {32'hFE00_0000, 32'h8000_0000};
  localparam logic [N_LEGAL-1:0][ADDR_W-1:0] LEGAL_HI = {32'hFEFF_FFFF, 32'hFCFF_FFFF};

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_MEM  = 2'b01,
    TGT_REG  = 2'b10
  } tgt_e;

  typedef enum logic [1:0] {
    CSEL_CTRL = 2'b00,
    CSEL_BASE = 2'b01,
    CSEL_TOM  = 2'b10,
    CSEL_IDLE = 2'b11
  } csel_e;

  typedef struct packed {
    logic              alias_en;
    logic              hole_en;
    logic [BASE_W-1:0] base;
    logic [ADDR_W-1:0] tom;
  } cfg_t;

  typedef struct packed {
    logic              claim;
    tgt_e              tgt;
    logic [ADDR_W-1:0] xaddr;
  } dec_t;
endpackage

// File: rtl/pcidec_range.sv
`timescale 1ns/1ps
module pcidec_range #(
  parameter int               AW = 32,
  parameter logic [AW-1:0]    LO = '1,
  parameter logic [AW-1:0]    HI = '1
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb begin
    hit = (addr >= LO) && (addr <= HI);
  end
endmodule

// File: rtl/pcidec_cfg.sv
`timescale 1ns/1ps
module pcidec_cfg
  import pcidec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output cfg_t              cfg,
  output logic              err
);
  cfg_t               cfg_q, cfg_d;
  logic               err_q, err_d;
  logic [N_LEGAL-1:0] legal_hit;
  logic               base_ok;

  for (genvar g = 0; g < N_LEGAL; g++) begin : g_legal
    pcidec_range #(
      .AW (ADDR_W),
      .LO (LEGAL_LO[g]),
      .HI (LEGAL_HI[g])
    ) u_rng (
      .addr (wdata),
      .hit  (legal_hit[g])
    );
  end

  always_comb begin
    base_ok = |legal_hit;
  end

  always_comb begin
    cfg_d = cfg_q;
    err_d = 1'b0;
    if (wr_en) begin
      case (csel_e'(sel))
        CSEL_CTRL: begin
          cfg_d.alias_en = wdata[0];
          cfg_d.hole_en  = wdata[1];
        end
        CSEL_BASE: begin
          if (base_ok) cfg_d.base = wdata[ADDR_W-1:WIN_LG2];
          else         err_d      = 1'b1;
        end
        CSEL_TOM:  cfg_d.tom = wdata;
        default:   cfg_d = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.alias_en <= 1'b0;
      cfg_q.hole_en  <= 1'b0;
      cfg_q.base     <= BASE_RST[ADDR_W-1:WIN_LG2];
      cfg_q.tom      <= '0;
      err_q          <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;

  // R8: the stored base always lies inside one of the permitted ranges
  a_r8_base_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (({cfg_q.base, {WIN_LG2{1'b0}}} >= LEGAL_LO[0]) && ({cfg_q.base, {WIN_LG2{1'b0}}} <= LEGAL_HI[0])) ||
    (({cfg_q.base, {WIN_LG2{1'b0}}} >= LEGAL_LO[1]) && ({cfg_q.base, {WIN_LG2{1'b0}}} <= LEGAL_HI[1])));

  // R8: an error pulse is always caused by a base write one cycle earlier
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(wr_en && (sel == CSEL_BASE)));

  // R8: a refused base write leaves the base untouched
  a_r8_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(cfg_q.base));
endmodule

// File: rtl/pcidec_classify.sv
`timescale 1ns/1ps
module pcidec_classify
  import pcidec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  cfg_t              cfg,
  output dec_t              dec
);
  logic             win_hit;
  logic             hole_hit;
  logic             below_tom;
  logic [SEG_W-1:0] seg;

  pcidec_range #(
    .AW (ADDR_W),
    .LO (HOLE_LO),
    .HI (HOLE_HI)
  ) u_hole (
    .addr (addr),
    .hit  (hole_hit)
  );

  always_comb begin
    seg       = addr[ADDR_W-1:SEG_LSB];
    win_hit   = (addr[ADDR_W-1:WIN_LG2] == cfg.base);
    below_tom = (addr < cfg.tom);
  end

  // priority: register window, alias, reserved, hole, memory
  always_comb begin
    dec.claim = 1'b0;
    dec.tgt   = TGT_NONE;
    dec.xaddr = '0;
    if (win_hit) begin
      dec.claim                = 1'b1;
      dec.tgt                  = TGT_REG;
      dec.xaddr[WIN_LG2-1:0]   = addr[WIN_LG2-1:0];
    end else if (seg == SEG_ALIAS) begin
      if (cfg.alias_en) begin
        dec.claim              = 1'b1;
        dec.tgt                = TGT_MEM;
        dec.xaddr[SEG_LSB-1:0] = addr[SEG_LSB-1:0];
      end
    end else if (seg == SEG_RSVD) begin
      dec.claim = 1'b0;
    end else if (cfg.hole_en && hole_hit) begin
      dec.claim = 1'b0;
    end else if (below_tom) begin
      dec.claim = 1'b1;
      dec.tgt   = TGT_MEM;
      dec.xaddr = addr;
    end
  end
endmodule

// File: rtl/pcidec_outreg.sv
`timescale 1ns/1ps
module pcidec_outreg
  import pcidec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  dec_t              dec,
  output logic              out_valid,
  output logic              out_claim,
  output logic [1:0]        out_tgt,
  output logic [ADDR_W-1:0] out_addr
);
  logic valid_q, valid_d;
  dec_t res_q, res_d;

  always_comb begin
    valid_d = in_valid;
    res_d   = res_q;
    if (in_valid) res_d = dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      res_q.claim <= 1'b0;
      res_q.tgt   <= TGT_NONE;
      res_q.xaddr <= '0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
    end
  end

  assign out_valid = valid_q;
  assign out_claim = res_q.claim;
  assign out_tgt   = res_q.tgt;
  assign out_addr  = res_q.xaddr;

  // R2: result valid exactly one cycle after the strobe
  a_r2_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q == $past(in_valid));

  // R2: without a strobe the result fields hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(res_q));

  // R10: an unclaimed result names no target and carries a zero address
  a_r10_none_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !res_q.claim) |-> (res_q.tgt == TGT_NONE && res_q.xaddr == '0));
endmodule

// File: rtl/pci_inb_decode.sv
`timescale 1ns/1ps
module pci_inb_decode
  import pcidec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_err,
  output logic              out_valid,
  output logic              out_claim,
  output logic [1:0]        out_tgt,
  output logic [ADDR_W-1:0] out_addr
);
  cfg_t cfg;
  dec_t dec;

  pcidec_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .err   (cfg_err)
  );

  pcidec_classify u_cls (
    .addr (in_addr),
    .cfg  (cfg),
    .dec  (dec)
  );

  pcidec_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dec       (dec),
    .out_valid (out_valid),
    .out_claim (out_claim),
    .out_tgt   (out_tgt),
    .out_addr  (out_addr)
  );

  // R5: the reserved segment never reaches memory
  a_r5_rsvd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[ADDR_W-1:SEG_LSB] == SEG_RSVD) |=> (out_tgt != TGT_MEM));

  // R3: forwarded alias cycles lose their top byte
  a_r3_alias_strip: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[ADDR_W-1:SEG_LSB] == SEG_ALIAS && out_tgt != TGT_REG && cfg.alias_en)
      |=> (out_tgt == TGT_REG || (out_claim && out_addr[ADDR_W-1:SEG_LSB] == '0)));

  // R6, R7: a window hit is always routed to registers
  a_r7_window_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[ADDR_W-1:WIN_LG2] == cfg.base) |=> (out_claim && out_tgt == TGT_REG));

  // R6: register offsets stay inside the window
  a_r6_reg_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tgt == TGT_REG) |-> (out_addr[ADDR_W-1:WIN_LG2] == '0));
endmodule

// File: tb/pci_inb_decode_tb_top.sv
`timescale 1ns/1ps
module pci_inb_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_addr;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        cfg_err;
  logic        out_valid;
  logic        out_claim;
  logic [1:0]  out_tgt;
  logic [31:0] out_addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pci_inb_decode dut_i (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_addr (in_addr),
    .cfg_wr (cfg_wr), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
    .cfg_err (cfg_err),
    .out_valid (out_valid), .out_claim (out_claim),
    .out_tgt (out_tgt), .out_addr (out_addr)
  );

  // {ctrl[1:0], addr, claim, tgt[1:0], xaddr}; base 0x8000_0000, top 0x1000_0000
  localparam int NV = 13;
  localparam logic [68:0] VEC [NV] = '{
    {2'b01, 32'hFD12_3456, 1'b1, 2'b01, 32'h0012_3456},  // R3
    {2'b01, 32'hFDFF_FFFF, 1'b1, 2'b01, 32'h00FF_FFFF},  // R3
    {2'b00, 32'hFD12_3456, 1'b0, 2'b00, 32'h0000_0000},  // R4
    {2'b01, 32'hFE00_1000, 1'b0, 2'b00, 32'h0000_0000},  // R5
    {2'b10, 32'h000A_0000, 1'b0, 2'b00, 32'h0000_0000},  // R9
    {2'b10, 32'h000F_FFFF, 1'b0, 2'b00, 32'h0000_0000},  // R9
    {2'b10, 32'h0010_0000, 1'b1, 2'b01, 32'h0010_0000},  // R9
    {2'b11, 32'h0009_FFFF, 1'b1, 2'b01, 32'h0009_FFFF},  // R9
    {2'b00, 32'h000B_0004, 1'b1, 2'b01, 32'h000B_0004},  // R9
    {2'b00, 32'h0FFF_FFFC, 1'b1, 2'b01, 32'h0FFF_FFFC},  // R10
    {2'b00, 32'h1000_0000, 1'b0, 2'b00, 32'h0000_0000},  // R10
    {2'b00, 32'h8000_0ABC, 1'b1, 2'b10, 32'h0000_0ABC},  // R6
    {2'b00, 32'h8000_1000, 1'b0, 2'b00, 32'h0000_0000}   // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d, output logic err_seen);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_sel   = s;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr    = 1'b0;
    cfg_sel   = 2'b11;
    err_seen  = cfg_err;
  endtask

  task automatic expect_dec(input string tag, input logic c, input logic [1:0] t, input logic [31:0] a);
    check({tag, " claim"}, {31'h0, out_claim}, {31'h0, c});
    check({tag, " tgt"},   {30'h0, out_tgt},   {30'h0, t});
    check({tag, " addr"},  out_addr, a);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic e;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
    cfg_wr = 1'b0; cfg_sel = 2'b11; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 cfg_err",   {31'h0, cfg_err},   32'h0);
    expect_dec("R1 outputs", 1'b0, 2'b00, 32'h0);
    strobe(32'hFD00_0010);
    expect_dec("R1 alias off", 1'b0, 2'b00, 32'h0);
    strobe(32'h0000_0040);
    expect_dec("R1 top zero", 1'b0, 2'b00, 32'h0);
    strobe(32'h8000_0004);
    expect_dec("R1 base", 1'b1, 2'b10, 32'h0000_0004);

    // table walk
    cfg_write(2'b10, 32'h1000_0000, e);
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'b00, {30'h0, VEC[i][68:67]}, e);
      strobe(VEC[i][66:35]);
      check($sformatf("vec%0d valid R2", i), {31'h0, out_valid}, 32'h1);
      expect_dec($sformatf("vec%0d", i), VEC[i][34], VEC[i][33:32], VEC[i][31:0]);
    end

    // R2 timing and hold
    strobe(32'h0000_1230);
    check("R2 valid", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    check("R2 drop", {31'h0, out_valid}, 32'h0);
    check("R2 hold", out_addr, 32'h0000_1230);

    // R7 window over reserved segment and over memory
    cfg_write(2'b01, 32'hFE00_0000, e);
    check("R7 legal err", {31'h0, e}, 32'h0);
    strobe(32'hFE00_0010);
    expect_dec("R7 rsvd", 1'b1, 2'b10, 32'h0000_0010);
    cfg_write(2'b10, 32'hFFFF_FFFF, e);
    cfg_write(2'b01, 32'h8000_0000, e);
    strobe(32'h8000_0020);
    expect_dec("R7 mem", 1'b1, 2'b10, 32'h0000_0020);

    // R8 refused writes
    cfg_write(2'b01, 32'hFD00_0000, e);
    check("R8 err alias", {31'h0, e}, 32'h1);
    @(negedge clk);
    check("R8 err one cycle", {31'h0, cfg_err}, 32'h0);
    strobe(32'h8000_0008);
    expect_dec("R8 base kept", 1'b1, 2'b10, 32'h0000_0008);
    cfg_write(2'b01, 32'h7FFF_F000, e);
    check("R8 err low", {31'h0, e}, 32'h1);
    cfg_write(2'b01, 32'hFF00_0000, e);
    check("R8 err high", {31'h0, e}, 32'h1);
    cfg_write(2'b01, 32'hFCFF_F123, e);
    check("R8 edge legal", {31'h0, e}, 32'h0);
    strobe(32'hFCFF_F004);
    expect_dec("R8 new base", 1'b1, 2'b10, 32'h0000_0004);
    strobe(32'h8000_0008);
    expect_dec("R8 old base freed", 1'b1, 2'b01, 32'h8000_0008);

    // R11 write and strobe in the same cycle
    cfg_write(2'b00, 32'h0, e);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'b00; cfg_wdata = 32'h1;
    in_valid = 1'b1; in_addr = 32'hFD00_0100;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sel = 2'b11; in_valid = 1'b0;
    expect_dec("R11 old cfg", 1'b0, 2'b00, 32'h0);
    strobe(32'hFD00_0100);
    expect_dec("R11 new cfg", 1'b1, 2'b01, 32'h0000_0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule